// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

The engine copies a block of elements from a source address to a destination address over a single request/acknowledge memory port. For each element it issues one read at the source width, then writes that value at the destination width. Each side's address then moves up, moves down or stays put, by that side's element size. The block is set up by a start pulse that loads a 16-bit control word, an element count, two start addresses and a chain pointer. When the count runs out and the chain pointer is nonzero, the engine itself reads an eight-word descriptor from memory and carries on with the block that descriptor describes.

A peripheral request line can pace the work. Each request releases either one burst or the whole block. The burst length comes from a 4-bit code that is read either as a power of two or as a length minus one. The engine emits single-cycle event pulses for terminal count, half count, error and abort. It also exposes its sequencer state and the remaining element count.

Top module: `dma_chan_engine`

## Requirements
- R1: After synchronous active-low reset the engine is idle: `state` is 0, `ch_en`, `mem_req`, `remain` and all four event outputs are 0. `ch_en` is 1 exactly when `state` is not 0.
- R2: Each element passes through the states read (1), read-wait (2), write (3) and write-wait (4). `mem_req` is a one-cycle pulse. A read uses the source width code as `mem_size`. The write that follows uses the destination width code. Width code w means 2^w bytes. The written value is the element read, with the bytes above the source size set to zero.
- R3: `cfg_count` counts elements of source width. `remain` drops by one after each completed write. `ev_tc` pulses in the cycle after the write that brings `remain` to 0. Without a chain pointer or loop mode, the channel then returns to idle through states 6 and 7.
- R4: Address mode 0 adds the side's element size after each element, mode 1 subtracts it, and mode 2 keeps the address. Source and destination follow their own modes.
- R5: `ev_half` pulses once per block, after the write that leaves `remain` equal to floor(count/2). With a count of 1 it falls in the same cycle as `ev_tc`.
- R6: Control layout: bits [1:0] source width, [3:2] destination width, [5:4] source address mode, [7:6] destination address mode, [11:8] burst code c, [12] burst form, [13] loop, [14] request pacing enable, [15] pacing scope. With form 0 a burst is 2^c elements, with c capped at 10. With form 1 it is c+1 elements. With pacing on and scope 0, each `dreq` pulse releases one burst.
- R7: With pacing on and scope 1, a single `dreq` pulse releases the whole block.
- R8: A nonzero chain pointer at terminal count makes the engine read eight 32-bit words at pointer+4i, i = 0..7, in state 5. Word 0 is the new control word (low 16 bits), word 1 the count, word 2 the source address, word 4 the destination address and word 6 the next pointer. Words 3, 5 and 7 are ignored. A zero pointer ends the chain.
- R9: With the loop bit set and no chain pointer, the engine restarts the same block from its original addresses and count after each terminal count.
- R10: An error response to any read, write or descriptor read drops `ch_en`, returns the engine to idle and pulses `ev_err`. The failing element is not counted.
- R11: An `abort` pulse while the channel runs returns the engine to idle when it next reaches the read state, drops `ch_en` and pulses `ev_abort`. An `abort` while idle has no effect on the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load configuration and start (ignored while running) |
| abort | input | 1 | Stop request |
| cfg_ctrl | input | 16 | Control word (layout in R6) |
| cfg_count | input | CW | Element count in source-width units |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_link | input | AW | Chain pointer, 0 for none |
| dreq | input | 1 | Peripheral request |
| mem_req | output | 1 | Memory access request pulse |
| mem_we | output | 1 | 1 for a write |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access done |
| mem_err | input | 1 | Access failed (valid with `mem_ack`) |
| mem_rdata | input | DW | Read data (valid with `mem_ack`) |
| ch_en | output | 1 | Channel running |
| state | output | 3 | Sequencer state code |
| remain | output | CW | Remaining element count |
| ev_tc | output | 1 | Terminal count pulse |
| ev_half | output | 1 | Half count pulse |
| ev_err | output | 1 | Error pulse |
| ev_abort | output | 1 | Abort pulse |

## Verification
The half-count and terminal-count events come from the same write completion, so a block of one element makes them fire in the same cycle. The bench runs a one-element block and a four-element block and stamps each event pulse with its cycle number. With one element the two stamps must be equal. With four elements the half-count stamp must come exactly two element times (eight cycles) before the terminal count.

// File: rtl/dma_eng_pkg.sv
// Shared types for the DMA channel engine.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package dma_eng_pkg;

    // Sequencer states; the codes are visible on the state output.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD       = 3'd1,
        ST_RD_ACK   = 3'd2,
        ST_WR       = 3'd3,
        ST_WR_ACK   = 3'd4,
        ST_LINK     = 3'd5,
        ST_END      = 3'd6,
        ST_END_WAIT = 3'd7
    } eng_state_e;

    // Channel control word, bit 15 first.
    typedef struct packed {
        logic       hs_whole;   // 1: one request moves the whole block
        logic       hs_en;      // request pacing enable
        logic       loop;       // restart after terminal count
        logic       blen_lin;   // 1: burst = code + 1, 0: burst = 2^code
        logic [3:0] bcode;
        logic [1:0] dmode;
        logic [1:0] smode;
        logic [1:0] dwid;
        logic [1:0] swid;
    } ch_ctrl_t;

    localparam logic [1:0] AM_INC = 2'd0;
    localparam logic [1:0] AM_DEC = 2'd1;
    localparam int         DESC_LAST = 7;

endpackage

// File: rtl/dma_addr_step.sv
// Next-address calculator for one side of the channel.
// Assumes the element size is 2^width bytes; modes other than
// increment and decrement hold the address.
module dma_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    mode_i,
    input  logic [1:0]    width_i,
    output logic [AW-1:0] addr_o
);
    import dma_eng_pkg::*;

    logic [AW-1:0] step;

    // Pick the next address from the side's mode.
    always_comb begin
        step = AW'(1) << width_i;
        case (mode_i)
            AM_INC:  addr_o = addr_i + step;
            AM_DEC:  addr_o = addr_i - step;
            default: addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/dma_burst_len.sv
// Burst length decoder: power-of-two form (code capped at LW-1)
// or linear form (code + 1).
module dma_burst_len #(
    parameter int LW = 11
) (
    input  logic [3:0]    code_i,
    input  logic          lin_i,
    output logic [LW-1:0] len_o
);
    localparam int MAXC = LW - 1;

    // Decode the burst code to an element count.
    always_comb begin
        if (lin_i)
            len_o = LW'(code_i) + LW'(1);
        else if (int'(code_i) > MAXC)
            len_o = LW'(1) << MAXC;
        else
            len_o = LW'(1) << code_i;
    end
endmodule

// File: rtl/dma_chan_engine.sv
// Single-channel DMA engine: read-then-write per element, per-side
// address stepping, burst pacing by dreq, half/terminal count events,
// loop restart and self-fetched eight-word chained descriptors.
// Assumes AW <= 32 and CW <= 32 (descriptor words are 32 bits) and
// DW = 64 so that a double-word element fits the data path.
module dma_chan_engine #(
    parameter int AW = 32,
    parameter int DW = 64,
    parameter int CW = 16,
    parameter int BLW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [15:0]   cfg_ctrl,
    input  logic [CW-1:0] cfg_count,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [AW-1:0] cfg_link,
    input  logic          dreq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [DW-1:0] mem_rdata,
    output logic          ch_en,
    output logic [2:0]    state,
    output logic [CW-1:0] remain,
    output logic          ev_tc,
    output logic          ev_half,
    output logic          ev_err,
    output logic          ev_abort
);
    import dma_eng_pkg::*;

    localparam int NBYTES = DW / 8;
    localparam int NSIDE  = 2;   // 0 = source, 1 = destination

    eng_state_e    state_q;
    ch_ctrl_t      ctl_q;
    logic [CW-1:0] cnt_prog, remain_q, remain_n;
    logic [AW-1:0] addr_q [NSIDE];
    logic [AW-1:0] orig_q [NSIDE];
    logic [AW-1:0] addr_nxt [NSIDE];
    logic [1:0]    side_mode [NSIDE];
    logic [1:0]    side_wid [NSIDE];
    logic [AW-1:0] link_q, ll_base;
    logic [2:0]    ll_idx;
    logic          ll_wait;
    logic [BLW-1:0] burst_cnt, burst_len;
    logic          half_done, abort_q, en_q;
    logic [DW-1:0] data_q;
    logic [31:0]   word;
    logic          hs_need, go, burst_last;

    // Zero the bytes above the element size.
    function automatic logic [DW-1:0] keep_bytes(input logic [DW-1:0] d, input logic [1:0] w);
        for (int b = 0; b < NBYTES; b++)
            if (b >= (1 << w)) d[b*8 +: 8] = 8'h00;
        return d;
    endfunction

    assign side_mode[0] = ctl_q.smode;
    assign side_mode[1] = ctl_q.dmode;
    assign side_wid[0]  = ctl_q.swid;
    assign side_wid[1]  = ctl_q.dwid;

    generate
        for (genvar g = 0; g < NSIDE; g++) begin : g_side
            dma_addr_step #(.AW(AW)) u_step (
                .addr_i (addr_q[g]),
                .mode_i (side_mode[g]),
                .width_i(side_wid[g]),
                .addr_o (addr_nxt[g])
            );
        end
    endgenerate

    dma_burst_len #(.LW(BLW)) u_blen (
        .code_i(ctl_q.bcode),
        .lin_i (ctl_q.blen_lin),
        .len_o (burst_len)
    );

    // Pacing and count helpers.
    always_comb begin
        hs_need    = ctl_q.hs_whole ? (remain_q == cnt_prog) : (burst_cnt == '0);
        go         = !ctl_q.hs_en || !hs_need || dreq;
        remain_n   = remain_q - CW'(1);
        burst_last = (burst_cnt + BLW'(1)) == burst_len;
        word       = mem_rdata[31:0];
    end

    // Memory port drive from the current state.
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = addr_q[0];
        mem_size = ctl_q.swid;
        case (state_q)
            ST_RD:   mem_req = go && !abort_q;
            ST_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = addr_q[1];
                mem_size = ctl_q.dwid;
            end
            ST_LINK: begin
                mem_req  = !ll_wait;
                mem_addr = ll_base + AW'({ll_idx, 2'b00});
                mem_size = 2'd2;
            end
            default: ;
        endcase
    end

    assign mem_wdata = data_q;
    assign ch_en     = en_q;
    assign state     = state_q;
    assign remain    = remain_q;

    // Sequencer, counters, addresses and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ctl_q     <= '0;
            cnt_prog  <= '0;
            remain_q  <= '0;
            addr_q[0] <= '0;
            addr_q[1] <= '0;
            orig_q[0] <= '0;
            orig_q[1] <= '0;
            link_q    <= '0;
            ll_base   <= '0;
            ll_idx    <= '0;
            ll_wait   <= 1'b0;
            burst_cnt <= '0;
            half_done <= 1'b0;
            abort_q   <= 1'b0;
            en_q      <= 1'b0;
            data_q    <= '0;
            ev_tc     <= 1'b0;
            ev_half   <= 1'b0;
            ev_err    <= 1'b0;
            ev_abort  <= 1'b0;
        end else begin
            ev_tc    <= 1'b0;
            ev_half  <= 1'b0;
            ev_err   <= 1'b0;
            ev_abort <= 1'b0;
            if (abort && en_q) abort_q <= 1'b1;
            case (state_q)
                ST_IDLE: begin
                    abort_q <= 1'b0;
                    if (start) begin
                        ctl_q     <= ch_ctrl_t'(cfg_ctrl);
                        cnt_prog  <= cfg_count;
                        remain_q  <= cfg_count;
                        addr_q[0] <= cfg_src;
                        addr_q[1] <= cfg_dst;
                        orig_q[0] <= cfg_src;
                        orig_q[1] <= cfg_dst;
                        link_q    <= cfg_link;
                        half_done <= 1'b0;
                        burst_cnt <= '0;
                        en_q      <= 1'b1;
                        state_q   <= (cfg_count == '0) ? ST_END : ST_RD;
                    end
                end
                ST_RD: begin
                    if (abort_q) begin
                        state_q  <= ST_IDLE;
                        en_q     <= 1'b0;
                        abort_q  <= 1'b0;
                        ev_abort <= 1'b1;
                    end else if (go) begin
                        state_q <= ST_RD_ACK;
                    end
                end
                ST_RD_ACK: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            state_q <= ST_IDLE;
                            en_q    <= 1'b0;
                            abort_q <= 1'b0;
                            ev_err  <= 1'b1;
                        end else begin
                            data_q  <= keep_bytes(mem_rdata, ctl_q.swid);
                            state_q <= ST_WR;
                        end
                    end
                end
                ST_WR: state_q <= ST_WR_ACK;
                ST_WR_ACK: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            state_q <= ST_IDLE;
                            en_q    <= 1'b0;
                            abort_q <= 1'b0;
                            ev_err  <= 1'b1;
                        end else begin
                            addr_q[0] <= addr_nxt[0];
                            addr_q[1] <= addr_nxt[1];
                            remain_q  <= remain_n;
                            burst_cnt <= burst_last ? '0 : burst_cnt + BLW'(1);
                            if (remain_n == (cnt_prog >> 1) && !half_done) begin
                                ev_half   <= 1'b1;
                                half_done <= 1'b1;
                            end
                            if (remain_n == '0) begin
                                ev_tc   <= 1'b1;
                                state_q <= ST_END;
                            end else begin
                                state_q <= ST_RD;
                            end
                        end
                    end
                end
                ST_LINK: begin
                    if (!ll_wait) begin
                        ll_wait <= 1'b1;
                    end else if (mem_ack) begin
                        ll_wait <= 1'b0;
                        if (mem_err) begin
                            state_q <= ST_IDLE;
                            en_q    <= 1'b0;
                            abort_q <= 1'b0;
                            ev_err  <= 1'b1;
                        end else begin
                            case (ll_idx)
                                3'd0: ctl_q <= ch_ctrl_t'(word[15:0]);
                                3'd1: begin
                                    cnt_prog <= word[CW-1:0];
                                    remain_q <= word[CW-1:0];
                                end
                                3'd2: begin
                                    addr_q[0] <= word[AW-1:0];
                                    orig_q[0] <= word[AW-1:0];
                                end
                                3'd4: begin
                                    addr_q[1] <= word[AW-1:0];
                                    orig_q[1] <= word[AW-1:0];
                                end
                                3'd6: link_q <= word[AW-1:0];
                                default: ;
                            endcase
                            if (int'(ll_idx) == DESC_LAST) begin
                                half_done <= 1'b0;
                                burst_cnt <= '0;
                                state_q   <= (cnt_prog == '0) ? ST_END : ST_RD;
                            end else begin
                                ll_idx <= ll_idx + 3'd1;
                            end
                        end
                    end
                end
                ST_END: begin
                    if (link_q != '0) begin
                        ll_base <= link_q;
                        ll_idx  <= '0;
                        ll_wait <= 1'b0;
                        state_q <= ST_LINK;
                    end else if (ctl_q.loop && cnt_prog != '0) begin
                        remain_q  <= cnt_prog;
                        addr_q[0] <= orig_q[0];
                        addr_q[1] <= orig_q[1];
                        half_done <= 1'b0;
                        burst_cnt <= '0;
                        state_q   <= ST_RD;
                    end else begin
                        state_q <= ST_END_WAIT;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    en_q    <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_engine_chk.sv
// Property checker for dma_chan_engine, attached by bind below.
// Assumes synchronous active-low reset; all checks off in reset.
module dma_chan_engine_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          ch_en,
    input logic [2:0]    state,
    input logic [CW-1:0] remain,
    input logic          ev_tc,
    input logic          ev_half,
    input logic          ev_err,
    input logic          ev_abort
);
    assert_idle_iff_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0) == !ch_en);

    assert_req_in_issue_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (state == 3'd1 || state == 3'd3 || state == 3'd5));

    assert_req_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd3) |-> ($past(state) == 3'd2 && mem_we));

    assert_tc_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tc |-> (remain == '0));

    assert_half_with_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_half |-> $past(state) == 3'd4);

    assert_err_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |-> (!ch_en && state == 3'd0));

    assert_abort_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |-> (!ch_en && state == 3'd0));

    assert_one_ending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_tc, ev_err, ev_abort}));

    // The address is only meaningful with a request; keep it referenced.
    assert_addr_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !$isunknown(mem_addr));
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .ch_en   (ch_en),
    .state   (state),
    .remain  (remain),
    .ev_tc   (ev_tc),
    .ev_half (ev_half),
    .ev_err  (ev_err),
    .ev_abort(ev_abort)
);

// File: tb/tb_dma_chan_engine.sv
// Self-checking bench: width/mode sweep, event timing, bursts, chaining,
// loop, error and abort cases, expected values computed arithmetically.
module tb_dma_chan_engine;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int CW = 16;
    localparam int MSZ = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, abort = 1'b0, dreq = 1'b0;
    logic [15:0] cfg_ctrl = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0, cfg_link = '0;
    logic mem_req, mem_we, mem_ack, mem_err;
    logic [AW-1:0] mem_addr;
    logic [1:0] mem_size;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic ch_en, ev_tc, ev_half, ev_err, ev_abort;
    logic [2:0] state;
    logic [CW-1:0] remain;

    always #5 clk = ~clk;

    dma_chan_engine #(.AW(AW), .DW(DW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .cfg_ctrl(cfg_ctrl), .cfg_count(cfg_count), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .cfg_link(cfg_link), .dreq(dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .ch_en(ch_en),
        .state(state), .remain(remain), .ev_tc(ev_tc), .ev_half(ev_half),
        .ev_err(ev_err), .ev_abort(ev_abort)
    );

    // Memory model and its bench-side controls.
    logic [7:0] mem [MSZ];
    logic [7:0] exp_m [MSZ];
    logic init_go = 1'b0, poke_go = 1'b0, err_arm = 1'b0;
    logic [8:0] poke_a = '0;
    logic [7:0] poke_d = '0;
    logic [AW-1:0] err_addr = '0;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        mem_err <= 1'b0;
        if (init_go) for (int i = 0; i < MSZ; i++) mem[i] = 8'(i * 13 + 5);
        if (poke_go) mem[poke_a] = poke_d;
        if (mem_req) begin
            mem_ack <= 1'b1;
            if (err_arm && mem_addr == err_addr) begin
                mem_err <= 1'b1;
            end else if (mem_we) begin
                for (int b = 0; b < (1 << mem_size); b++)
                    mem[(int'(mem_addr[8:0]) + b) % MSZ] = mem_wdata[b*8 +: 8];
            end else begin
                logic [DW-1:0] v;
                v = '0;
                for (int b = 0; b < (1 << mem_size); b++)
                    v[b*8 +: 8] = mem[(int'(mem_addr[8:0]) + b) % MSZ];
                mem_rdata <= v;
            end
        end
    end

    // Event counters, cycle stamps and watchdog.
    int cyc = 0, n_tc = 0, n_half = 0, n_err = 0, n_abt = 0, tc_cyc = 0, half_cyc = 0;
    int n_run = 0, n_fail = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ev_tc) begin n_tc <= n_tc + 1; tc_cyc <= cyc; end
        if (ev_half) begin n_half <= n_half + 1; half_cyc <= cyc; end
        if (ev_err) n_err <= n_err + 1;
        if (ev_abort) n_abt <= n_abt + 1;
        if (cyc >= 190000) begin
            $display("FAIL watchdog: act=%0d exp=<190000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
        end
    endtask

    function automatic logic [15:0] mk(input int sw, dw, sm, dm, bc, bl, lp, he, hw);
        return {1'(hw), 1'(he), 1'(lp), 1'(bl), 4'(bc), 2'(dm), 2'(sm), 2'(dw), 2'(sw)};
    endfunction

    task automatic mem_init();
        @(negedge clk) init_go = 1'b1;
        @(negedge clk) init_go = 1'b0;
        for (int i = 0; i < MSZ; i++) exp_m[i] = 8'(i * 13 + 5);
    endtask

    task automatic poke_word(input int a, input logic [31:0] w);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            poke_go = 1'b1; poke_a = 9'(a + b); poke_d = w[b*8 +: 8];
            exp_m[a + b] = w[b*8 +: 8];
        end
        @(negedge clk) poke_go = 1'b0;
    endtask

    // Apply one block's element moves to the expected image.
    task automatic model(input int sw, dw, sm, dm, cnt, src, dst);
        int sa = src, da = dst;
        for (int e = 0; e < cnt; e++) begin
            logic [63:0] v = '0;
            for (int b = 0; b < (1 << sw); b++) v[b*8 +: 8] = exp_m[sa + b];
            for (int b = 0; b < (1 << dw); b++) exp_m[da + b] = v[b*8 +: 8];
            sa = (sm == 0) ? sa + (1 << sw) : (sm == 1) ? sa - (1 << sw) : sa;
            da = (dm == 0) ? da + (1 << dw) : (dm == 1) ? da - (1 << dw) : da;
        end
    endtask

    task automatic kick(input logic [15:0] c, input int cnt, src, dst, lnk);
        @(negedge clk);
        cfg_ctrl = c; cfg_count = CW'(cnt); cfg_src = AW'(src);
        cfg_dst = AW'(dst); cfg_link = AW'(lnk); start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (ch_en && t < 3000) begin @(negedge clk); t++; end
        if (t >= 3000) chk(1'b0, req, t, 3000);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_dreq();
        @(negedge clk) dreq = 1'b1;
        @(negedge clk) dreq = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    function automatic int mism();
        int m = 0;
        for (int i = 0; i < MSZ; i++) if (mem[i] !== exp_m[i]) m++;
        return m;
    endfunction

    initial begin
        int b_tc, b_half, b_err, b_abt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(state == 3'd0 && !ch_en && !mem_req && remain == '0, "R1 reset idle", state, 0);
        chk({ev_tc, ev_half, ev_err, ev_abort} == 4'b0, "R1 events quiet", {ev_tc, ev_half, ev_err, ev_abort}, 0);

        // R2 R3 R4 R5: sweep widths and address modes, count 3
        for (int sw = 0; sw < 4; sw++)
            for (int dw = 0; dw < 4; dw++)
                for (int sm = 0; sm < 3; sm++)
                    for (int dm = 0; dm < 3; dm++) begin
                        int src = (sm == 1) ? 160 : 96;
                        int dst = (dm == 1) ? 400 : 320;
                        mem_init();
                        model(sw, dw, sm, dm, 3, src, dst);
                        b_tc = n_tc; b_half = n_half;
                        kick(mk(sw, dw, sm, dm, 0, 0, 0, 0, 0), 3, src, dst, 0);
                        wait_idle("R3 sweep timeout");
                        chk(mism() == 0, "R2/R4 sweep image", mism(), 0);
                        chk(remain == '0 && n_tc - b_tc == 1, "R3 sweep count/tc", n_tc - b_tc, 1);
                        chk(n_half - b_half == 1, "R5 sweep half once", n_half - b_half, 1);
                    end

        // R5: count 1, half and tc in the same cycle
        mem_init();
        kick(mk(0, 0, 0, 0, 0, 0, 0, 0, 0), 1, 64, 96, 0);
        wait_idle("R5 timeout");
        chk(half_cyc == tc_cyc, "R5 count1 same cycle", half_cyc, tc_cyc);
        // R5: count 4, half two elements before tc
        kick(mk(0, 0, 0, 0, 0, 0, 0, 0, 0), 4, 64, 96, 0);
        wait_idle("R5 timeout");
        chk(tc_cyc - half_cyc == 8, "R5 count4 spacing", tc_cyc - half_cyc, 8);

        // R6: power-of-two burst, code 2 -> 4 elements per request
        kick(mk(0, 0, 0, 0, 2, 0, 0, 1, 0), 10, 64, 96, 0);
        repeat (30) @(negedge clk);
        chk(remain == 10 && state == 3'd1, "R6 waits for request", remain, 10);
        pulse_dreq();
        chk(remain == 6, "R6 pow2 burst", remain, 6);
        // R11: abort while waiting for the next request
        b_abt = n_abt;
        @(negedge clk) abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        repeat (4) @(negedge clk);
        chk(n_abt - b_abt == 1 && !ch_en && state == 3'd0, "R11 abort stops", n_abt - b_abt, 1);
        chk(remain == 6, "R11 abort keeps count", remain, 6);

        // R6: linear burst, code 2 -> 3 elements per request
        b_tc = n_tc;
        kick(mk(0, 0, 0, 0, 2, 1, 0, 1, 0), 7, 64, 96, 0);
        pulse_dreq();
        chk(remain == 4, "R6 linear burst 1", remain, 4);
        pulse_dreq();
        chk(remain == 1, "R6 linear burst 2", remain, 1);
        pulse_dreq();
        chk(!ch_en && n_tc - b_tc == 1, "R6 linear burst end", n_tc - b_tc, 1);

        // R7: one request moves the whole block
        b_tc = n_tc;
        kick(mk(0, 0, 0, 0, 0, 0, 0, 1, 1), 5, 64, 96, 0);
        repeat (20) @(negedge clk);
        chk(remain == 5, "R7 waits for request", remain, 5);
        pulse_dreq();
        chk(!ch_en && remain == 0 && n_tc - b_tc == 1, "R7 whole block", remain, 0);

        // R8: chained descriptor at 448, second block 200 -> 480
        mem_init();
        poke_word(448, 32'(mk(0, 0, 0, 0, 0, 0, 0, 0, 0)));
        poke_word(452, 32'd3);
        poke_word(456, 32'd200);
        poke_word(460, 32'hFFFF_FFFF);
        poke_word(464, 32'd480);
        poke_word(468, 32'hFFFF_FFFF);
        poke_word(472, 32'd0);
        poke_word(476, 32'hFFFF_FFFF);
        model(0, 0, 0, 0, 2, 64, 96);
        model(0, 0, 0, 0, 3, 200, 480);
        b_tc = n_tc;
        kick(mk(0, 0, 0, 0, 0, 0, 0, 0, 0), 2, 64, 96, 448);
        wait_idle("R8 timeout");
        chk(mism() == 0, "R8 chained image", mism(), 0);
        chk(n_tc - b_tc == 2 && remain == 0, "R8 two blocks", n_tc - b_tc, 2);

        // R9: loop restarts from the original addresses
        mem_init();
        model(0, 0, 0, 0, 2, 64, 96);
        b_tc = n_tc; b_abt = n_abt;
        kick(mk(0, 0, 0, 0, 0, 0, 1, 0, 0), 2, 64, 96, 0);
        begin
            int t = 0;
            while (n_tc - b_tc < 3 && t < 500) begin @(negedge clk); t++; end
        end
        chk(n_tc - b_tc >= 3 && ch_en, "R9 loop keeps running", n_tc - b_tc, 3);
        @(negedge clk) abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        wait_idle("R9 timeout");
        chk(n_abt - b_abt == 1, "R11 loop abort", n_abt - b_abt, 1);
        chk(mism() == 0, "R9 same addresses reused", mism(), 0);

        // R10: read error on third element
        mem_init();
        b_err = n_err;
        err_addr = 32'd66; err_arm = 1'b1;
        kick(mk(0, 0, 0, 0, 0, 0, 0, 0, 0), 5, 64, 96, 0);
        wait_idle("R10 timeout");
        chk(n_err - b_err == 1 && !ch_en, "R10 read error", n_err - b_err, 1);
        chk(remain == 3, "R10 read error count", remain, 3);
        // R10: write error on second element
        err_addr = 32'd97;
        kick(mk(0, 0, 0, 0, 0, 0, 0, 0, 0), 5, 64, 96, 0);
        wait_idle("R10 timeout");
        chk(n_err - b_err == 2 && remain == 4, "R10 write error", remain, 4);
        // R10: error on a descriptor word
        err_addr = 32'd456;
        kick(mk(0, 0, 0, 0, 0, 0, 0, 0, 0), 1, 64, 96, 448);
        wait_idle("R10 timeout");
        chk(n_err - b_err == 3 && state == 3'd0, "R10 descriptor error", n_err - b_err, 3);
        err_arm = 1'b0;

        // R11: abort while idle is ignored
        b_abt = n_abt; b_tc = n_tc;
        @(negedge clk) abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        kick(mk(0, 0, 0, 0, 0, 0, 0, 0, 0), 3, 64, 96, 0);
        wait_idle("R11 timeout");
        chk(n_abt == b_abt && n_tc - b_tc == 1, "R11 idle abort ignored", n_abt - b_abt, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule